// File: doc/BRIEF.md
# Program Counter with Boot Vector Load

This block holds the 16-bit address of the next instruction or operand byte that a small 8-bit processor core will fetch. In normal operation it steps forward by one address on every fetch strobe. It takes a supplied address instead when the core changes its flow of control, for example on a jump, a taken branch, interrupt entry or a return. Decoding, stack handling and the memory array belong to other blocks.

The counter does not start from zero. After reset is released it reads a two-byte start address from the top of the address space through a byte-wide memory read port. The byte at 0xFFFE is the high half and the byte at 0xFFFF is the low half. Only when both bytes are in hand does it raise `ready_o`. From then on the counter answers to the core's fetch and load strobes.

The read port is a request/response pair. A request is offered on `rd_valid_o` with `rd_addr_o`. It is held, address unchanged, until the memory accepts it by raising `rd_ready_i` in a cycle where `rd_valid_o` is high. The memory may stall for any number of cycles. After an accepted request the block waits for exactly one response, marked by `rd_data_valid_i`. It cannot stall a response, so responses are never back-pressured. Only one request is ever outstanding.

Top module: `pc_vector_unit`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0x0000, and `ready_o` and `rd_valid_o` are low. One clock edge after `rst_n` rises, `rd_valid_o` is high.
- R2: The boot sequence requests address 0xFFFE first and 0xFFFF second. Each request holds its address until accepted. No further request is raised until the response to the accepted one has arrived.
- R3: The byte returned for 0xFFFE becomes bits 15:8 of `pc_o`, and the byte returned for 0xFFFF becomes bits 7:0.
- R4: `ready_o` and the loaded start address both appear one clock edge after the second response. `ready_o` then stays high until the next reset.
- R5: With `ready_o` high, `fetch_i` high and `load_i` low, `pc_o` is one greater after the next clock edge.
- R6: With `ready_o` high and `load_i` high, `pc_o` equals `load_addr_i` after the next clock edge.
- R7: When `load_i` and `fetch_i` are both high, the load is taken and no increment is applied.
- R8: Stepping forward from 0xFFFF gives 0x0000.
- R9: While `ready_o` is low, `fetch_i` and `load_i` have no effect: `pc_o` stays 0x0000 and the start address that is loaded is unchanged.
- R10: Once `ready_o` is high, `rd_valid_o` stays low.
- R11: A `rd_data_valid_i` pulse while no request is outstanding is ignored and does not alter the loaded start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_i | input | 1 | Step to the next sequential address |
| load_i | input | 1 | Change of flow: take `load_addr_i` |
| load_addr_i | input | 16 | Target address for a change of flow |
| rd_valid_o | output | 1 | Boot read request is offered |
| rd_ready_i | input | 1 | Memory accepts the offered request |
| rd_addr_o | output | 16 | Address of the offered request |
| rd_data_valid_i | input | 1 | Response byte is present |
| rd_data_i | input | 8 | Response byte |
| pc_o | output | 16 | Current program counter |
| ready_o | output | 1 | Start address is loaded and the counter is live |

## Verification
Every result of the counter is due one rising edge after its cause. A fetch or load shows on `pc_o` after one edge. The first boot request shows one edge after reset release. Acceptance removes `rd_valid_o` after one edge. The final response brings up both `ready_o` and the start address after one edge. The bench drives every input on the falling edge and samples at the next falling edge, before it drives again, so each check lands exactly one edge after its stimulus. Boot runs sweep many start vectors, memory stall lengths, response delays and noise strobes, and a model computed in the bench then tracks several hundred mixed fetch and load steps.

// File: rtl/pcv_pkg.sv
`timescale 1ns/1ps
package pcv_pkg;
  typedef enum logic [1:0] {
    BOOT_IDLE = 2'd0,
    BOOT_REQ  = 2'd1,
    BOOT_WAIT = 2'd2,
    BOOT_RUN  = 2'd3
  } boot_state_e;
endpackage

// File: rtl/pcv_boot_seq.sv
`timescale 1ns/1ps
// Sequencer for the boot read: one outstanding request per vector byte.
module pcv_boot_seq #(
  parameter int                ADDR_W   = 16,
  parameter int                BYTES    = 2,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFFE,
  localparam int               IDX_W    = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_ready_i,
  input  logic              rd_data_valid_i,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              cap_o,
  output logic [IDX_W-1:0]  cap_lane_o,
  output logic              last_o,
  output logic              run_o
);
  import pcv_pkg::*;

  localparam logic [IDX_W-1:0] LAST_LANE = IDX_W'(BYTES - 1);

  boot_state_e      state_q, state_d;
  logic [IDX_W-1:0] lane_q, lane_d;

  always_comb begin
    state_d = state_q;
    lane_d  = lane_q;
    unique case (state_q)
      BOOT_IDLE: state_d = BOOT_REQ;
      BOOT_REQ:  if (rd_ready_i) state_d = BOOT_WAIT;
      BOOT_WAIT: begin
        if (rd_data_valid_i) begin
          if (lane_q == LAST_LANE) begin
            state_d = BOOT_RUN;
          end else begin
            state_d = BOOT_REQ;
            lane_d  = lane_q + 1'b1;
          end
        end
      end
      default:   state_d = BOOT_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BOOT_IDLE;
      lane_q  <= '0;
    end else begin
      state_q <= state_d;
      lane_q  <= lane_d;
    end
  end

  assign rd_valid_o = (state_q == BOOT_REQ);
  assign rd_addr_o  = VEC_BASE + ADDR_W'(lane_q);
  assign cap_o      = (state_q == BOOT_WAIT) && rd_data_valid_i;
  assign cap_lane_o = lane_q;
  assign last_o     = cap_o && (lane_q == LAST_LANE);
  assign run_o      = (state_q == BOOT_RUN);
endmodule

// File: rtl/pcv_vec_assemble.sv
`timescale 1ns/1ps
// Collects vector bytes, most significant first; the final byte is passed
// straight through so the counter can load in the same edge it arrives.
module pcv_vec_assemble #(
  parameter int  ADDR_W = 16,
  parameter int  DATA_W = 8,
  parameter int  BYTES  = 2,
  localparam int IDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic [IDX_W-1:0]  lane_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] vec_o
);
  assign vec_o[DATA_W-1:0] = data_i;

  for (genvar g = 0; g < BYTES - 1; g++) begin : g_lane
    localparam int HI = ADDR_W - 1 - g * DATA_W;
    logic [DATA_W-1:0] byte_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               byte_q <= '0;
      else if (cap_i && lane_i == IDX_W'(g))    byte_q <= data_i;
    end

    assign vec_o[HI -: DATA_W] = byte_q;
  end
endmodule

// File: rtl/pcv_addr_reg.sv
`timescale 1ns/1ps
// The counter register and its next-address choice.
module pcv_addr_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_load_i,
  input  logic [ADDR_W-1:0] boot_vec_i,
  input  logic              run_i,
  input  logic              fetch_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  output logic [ADDR_W-1:0] pc_o
);
  logic [ADDR_W-1:0] pc_q, pc_d;

  always_comb begin
    pc_d = pc_q;
    if (boot_load_i)           pc_d = boot_vec_i;
    else if (run_i && load_i)  pc_d = load_addr_i;
    else if (run_i && fetch_i) pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/pc_vector_unit.sv
`timescale 1ns/1ps
module pc_vector_unit #(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFFE,
  localparam int               BYTES    = ADDR_W / DATA_W,
  localparam int               IDX_W    = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_data_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              ready_o
);
  logic              cap;
  logic [IDX_W-1:0]  cap_lane;
  logic              last;
  logic              run;
  logic [ADDR_W-1:0] vec;

  pcv_boot_seq #(
    .ADDR_W(ADDR_W), .BYTES(BYTES), .VEC_BASE(VEC_BASE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .rd_ready_i(rd_ready_i), .rd_data_valid_i(rd_data_valid_i),
    .rd_valid_o(rd_valid_o), .rd_addr_o(rd_addr_o),
    .cap_o(cap), .cap_lane_o(cap_lane), .last_o(last), .run_o(run)
  );

  pcv_vec_assemble #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTES(BYTES)
  ) u_vec (
    .clk(clk), .rst_n(rst_n),
    .cap_i(cap), .lane_i(cap_lane), .data_i(rd_data_i), .vec_o(vec)
  );

  pcv_addr_reg #(
    .ADDR_W(ADDR_W)
  ) u_pc (
    .clk(clk), .rst_n(rst_n),
    .boot_load_i(last), .boot_vec_i(vec), .run_i(run),
    .fetch_i(fetch_i), .load_i(load_i), .load_addr_i(load_addr_i),
    .pc_o(pc_o)
  );

  assign ready_o = run;
endmodule

// File: rtl/pcv_checker.sv
`timescale 1ns/1ps
module pcv_checker #(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFFE
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_i,
  input logic              load_i,
  input logic [ADDR_W-1:0] load_addr_i,
  input logic              rd_valid_o,
  input logic              rd_ready_i,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_data_valid_i,
  input logic [DATA_W-1:0] rd_data_i,
  input logic [ADDR_W-1:0] pc_o,
  input logic              ready_o
);
  localparam int BYTES = ADDR_W / DATA_W;

  a_r2_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o));

  a_r2_vector_window: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> (ADDR_W'(rd_addr_o - VEC_BASE) < ADDR_W'(BYTES)));

  a_r2_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && rd_ready_i |=> !rd_valid_o);

  a_r4_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o);

  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o && fetch_i && !load_i |=> pc_o == ADDR_W'($past(pc_o) + 1'b1));

  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o && load_i |=> pc_o == $past(load_addr_i));

  a_r9_frozen_in_boot: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |=> ready_o || $stable(pc_o));

  a_r10_quiet_port: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> !rd_valid_o);

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o && !fetch_i && !load_i |=> $stable(pc_o));
endmodule

bind pc_vector_unit pcv_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_BASE(VEC_BASE)
) u_chk (.*);

// File: tb/pc_vector_unit_test.sv
`timescale 1ns/1ps
module pc_vector_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_i = 1'b0, load_i = 1'b0;
  logic [15:0] load_addr_i = '0;
  logic        rd_valid_o, rd_ready_i = 1'b0;
  logic [15:0] rd_addr_o;
  logic        rd_data_valid_i = 1'b0;
  logic [7:0]  rd_data_i = '0;
  logic [15:0] pc_o;
  logic        ready_o;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pc_vector_unit uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Boot run: memory stalls each request `stall` cycles, answers `lat` cycles
  // after acceptance; `noise` raises fetch/load and stray responses meanwhile.
  task automatic boot(input logic [15:0] vec, input int stall, input int lat, input bit noise);
    rst_n = 1'b0; fetch_i = 0; load_i = 0; rd_ready_i = 0; rd_data_valid_i = 0;
    repeat (3) @(negedge clk);
    chk(pc_o == 16'h0, "R1 pc in reset", pc_o, 0);
    chk(!ready_o && !rd_valid_o, "R1 ready/rd_valid in reset", {ready_o, rd_valid_o}, 0);
    rst_n = 1'b1;
    fetch_i = noise; load_i = noise; load_addr_i = 16'h5A5A;
    @(negedge clk);
    chk(rd_valid_o == 1'b1, "R1 request after release", rd_valid_o, 1);
    for (int b = 0; b < 2; b++) begin
      chk(rd_valid_o && rd_addr_o == 16'hFFFE + b, "R2 request address", rd_addr_o, 16'hFFFE + b);
      chk(pc_o == 16'h0 && !ready_o, "R9 pc frozen during boot", pc_o, 0);
      for (int s = 0; s < stall; s++) begin
        rd_data_valid_i = noise; rd_data_i = 8'hC3;   // R11 stray response
        @(negedge clk);
        chk(rd_valid_o && rd_addr_o == 16'hFFFE + b, "R2 request held", rd_addr_o, 16'hFFFE + b);
      end
      rd_data_valid_i = 1'b0;
      rd_ready_i = 1'b1;
      @(negedge clk);
      rd_ready_i = 1'b0;
      chk(!rd_valid_o, "R2 no second request before response", rd_valid_o, 0);
      for (int w = 0; w < lat; w++) begin
        @(negedge clk);
        chk(!rd_valid_o && !ready_o, "R2 waiting for response", {rd_valid_o, ready_o}, 0);
      end
      rd_data_valid_i = 1'b1;
      rd_data_i = (b == 0) ? vec[15:8] : vec[7:0];
      @(negedge clk);
      rd_data_valid_i = 1'b0;
    end
    chk(ready_o == 1'b1, "R4 ready after second byte", ready_o, 1);
    chk(pc_o[15:8] == vec[15:8], "R3 high byte from 0xFFFE", pc_o[15:8], vec[15:8]);
    chk(pc_o[7:0] == vec[7:0], "R3 low byte from 0xFFFF", pc_o[7:0], vec[7:0]);
    if (noise) chk(pc_o == vec, "R9 R11 vector unaffected by noise", pc_o, vec);
    fetch_i = 0; load_i = 0;
  endtask

  initial begin : main
    logic [15:0] model;
    logic [15:0] lfsr;
    for (int k = 0; k < 14; k++) begin
      logic [15:0] v;
      v = (k == 12) ? 16'hFFFF : (k == 13) ? 16'h0000 : 16'((k * 16'h1357) ^ 16'hA5F0);
      boot(v, k % 3, (k / 3) % 3, k[0]);
    end
    boot(16'hFFFC, 1, 1, 1'b1);
    model = 16'hFFFC;
    // R4 sticky and R10 quiet port while idle
    repeat (3) begin
      @(negedge clk);
      chk(ready_o && !rd_valid_o, "R4 R10 stays ready, no reads", {ready_o, rd_valid_o}, 2'b10);
      chk(pc_o == model, "R5 idle holds", pc_o, model);
    end
    // R8 wrap
    fetch_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      model = model + 1'b1;
      chk(pc_o == model, "R8 R5 step across wrap", pc_o, model);
    end
    // R7 load beats fetch
    load_i = 1'b1; load_addr_i = 16'h8000;
    @(negedge clk);
    model = 16'h8000;
    chk(pc_o == model, "R7 load wins over fetch", pc_o, model);
    load_i = 1'b0; fetch_i = 1'b0;
    // Mixed sweep with model computed arithmetically
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      fetch_i = lfsr[0];
      load_i = lfsr[3] & lfsr[5];
      load_addr_i = {lfsr[7:0], lfsr[15:8]};
      if (load_i) model = load_addr_i;
      else if (fetch_i) model = model + 1'b1;
      @(negedge clk);
      chk(pc_o == model, load_i ? "R6 R7 load" : "R5 step", pc_o, model);
      chk(!rd_valid_o && ready_o, "R10 no reads after ready", rd_valid_o, 0);
    end
    fetch_i = 0; load_i = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule